// File: doc/BRIEF.md
# Streaming Instruction Length Decoder for 64-bit x86 Code

This block sits on a byte stream of 64-bit-mode x86 machine code and marks where each instruction ends. Bytes arrive one per beat under a valid/ready handshake. The block walks each instruction's fields in order: legacy prefixes, an optional REX byte, the opcode with any escape bytes, then ModRM, SIB, displacement and immediate. When the last byte of an instruction is taken, it reports the total byte count, which opcode map the opcode came from, and a fault code.

The block does not execute or fully decode the instruction; it only counts bytes. It covers a defined subset of opcodes: the primary-map arithmetic group, the absolute-address (moffset) moves A0 to A3, and the three escaped maps. Any other primary opcode is reported as unsupported. After every report, successful or faulted, the next accepted byte starts a new instruction. A downstream fetch or predecode stage can therefore cut the stream into instructions without knowing their semantics.

Top module: `insn_len_scan`

## Requirements
- R1: The cycle after the final byte of an instruction is accepted, `done` is high for exactly one cycle. In that cycle `len` holds the instruction's total byte count, prefixes included, and `fault` holds 0 when the instruction is well formed. `done` stays low while an instruction is incomplete.
- R2: An instruction of exactly 15 bytes completes normally. If the 15th accepted byte does not complete the instruction, the block reports `fault`=3 with `len`=15, and the next byte starts a fresh instruction.
- R3: The bytes 66, 67, F0, F2, F3, 26, 2E, 36, 3E, 64 and 65 are prefixes. They may repeat in any number and each one adds to the length.
- R4: A byte 40h to 4Fh in prefix position is a REX byte, and its bit 3 is the W flag. A REX byte that is followed by a legacy prefix is dropped, and its W flag no longer applies.
- R5: A primary opcode with bits [7:6]=00 and bits [2:0] from 0 to 5 belongs to the arithmetic group. Low digits 0 to 3 take a ModRM byte. Digit 4 takes a 1-byte immediate. Digit 5 takes a 2-byte immediate when 66 is present and REX.W is clear; otherwise it takes a 4-byte immediate.
- R6: Primary opcodes 06 and 07 end the instruction at once with `fault`=2 and `map_id`=0.
- R7: Any primary opcode outside the supported set ends the instruction at once with `fault`=1 and `map_id`=0.
- R8: The ModRM fields are mod in bits [7:6] and r/m in bits [2:0]. With mod=11 nothing follows. With mod=01 a 1-byte displacement follows. With mod=10 a 4-byte displacement follows. With mod=00 and r/m=101 a 4-byte displacement follows.
- R9: When mod is not 11 and r/m=100, a SIB byte follows the ModRM byte. If that SIB byte has base bits [2:0]=101 and mod=00, a 4-byte displacement follows it.
- R10: Opcodes A0 to A3 carry an 8-byte absolute address, or a 4-byte one when 67 is present. They take no ModRM byte.
- R11: After 0F, `map_id`=1 is reported. In that map, opcodes 30 to 37 end the instruction, opcodes 80 to 8F take a 4-byte immediate, and every other opcode takes a ModRM byte.
- R12: 0F 38 selects `map_id`=2 and 0F 3A selects `map_id`=3. In both maps the opcode byte is followed by ModRM, and map 3 adds a 1-byte immediate after the addressing bytes.
- R13: A byte is taken only when `in_valid` is high; idle beats neither advance the count nor produce `done`. `insn_start` is high while the byte on `in_byte` would be the first byte of a new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Code byte |
| in_ready | output | 1 | Byte can be taken (low only in reset) |
| insn_start | output | 1 | Offered byte would begin a new instruction |
| done | output | 1 | One-cycle pulse: instruction complete |
| len | output | 4 | Total byte count of the finished instruction |
| map_id | output | 2 | 0 primary, 1 after 0F, 2 after 0F 38, 3 after 0F 3A |
| fault | output | 2 | 0 none, 1 unsupported, 2 invalid in 64-bit mode, 3 length limit |

## Verification
A wrong field state or a wrong remaining-byte count appears at the ports on the same instruction. `done` fires early or late, and `len` is off by the number of bytes that were miscounted. Because each report restarts the walk, a slipped boundary then misframes every later instruction. This shows up within one or two instructions as odd lengths, unsupported-opcode faults, or a length-limit fault no later than 15 bytes on. The directed cases pair each addressing and immediate rule with a specific expected length, so a single wrong byte count is visible.

// File: rtl/ilen_pkg.sv
package ilen_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_UNSUP = 2'd1,
        FLT_INV64 = 2'd2,
        FLT_LONG  = 2'd3
    } ilen_fault_e;

    typedef enum logic [1:0] {
        MAP_PRI  = 2'd0,
        MAP_0F   = 2'd1,
        MAP_0F38 = 2'd2,
        MAP_0F3A = 2'd3
    } ilen_map_e;

    typedef enum logic [2:0] {
        ST_PFX, ST_ESC, ST_ESC2, ST_MODRM, ST_SIB, ST_TAIL
    } ilen_state_e;

    // What a byte in opcode position demands next
    typedef enum logic [2:0] {
        LK_LEGACY, LK_REX, LK_ESC, LK_MODRM, LK_IMM, LK_DONE, LK_INV64, LK_UNSUP
    } ilen_kind_e;

    localparam int TAIL_W = 4;

    typedef struct packed {
        ilen_kind_e          kind;
        logic [TAIL_W-1:0]   tail;   // trailing bytes for LK_IMM
    } ilen_class_t;

    function automatic logic is_legacy_pfx(input logic [7:0] b);
        case (b)
            8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
            8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
            default:                           return 1'b0;
        endcase
    endfunction

    // Displacement bytes implied by a mod value and a low 3-bit field
    function automatic logic [TAIL_W-1:0] disp_bytes(input logic [1:0] md,
                                                     input logic [2:0] low3);
        case (md)
            2'b00:   return (low3 == 3'b101) ? TAIL_W'(4) : TAIL_W'(0);
            2'b01:   return TAIL_W'(1);
            2'b10:   return TAIL_W'(4);
            default: return TAIL_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/ilen_lead_class.sv
module ilen_lead_class
    import ilen_pkg::*;
(
    input  logic [7:0]  byte_in,
    input  logic        opsz16,
    input  logic        adsz32,
    output ilen_class_t cls
);
    always_comb begin
        cls.kind = LK_UNSUP;
        cls.tail = '0;
        if (is_legacy_pfx(byte_in)) begin
            cls.kind = LK_LEGACY;
        end else if (byte_in[7:4] == 4'h4) begin
            cls.kind = LK_REX;
        end else if (byte_in == 8'h0F) begin
            cls.kind = LK_ESC;
        end else if (byte_in == 8'h06 || byte_in == 8'h07) begin
            cls.kind = LK_INV64;
        end else if (byte_in[7:6] == 2'b00 && byte_in[2:0] <= 3'd5) begin
            if (!byte_in[2]) begin
                cls.kind = LK_MODRM;
            end else begin
                cls.kind = LK_IMM;
                if (!byte_in[0])
                    cls.tail = TAIL_W'(1);
                else
                    cls.tail = opsz16 ? TAIL_W'(2) : TAIL_W'(4);
            end
        end else if (byte_in[7:2] == 6'b101000) begin
            cls.kind = LK_IMM;
            cls.tail = adsz32 ? TAIL_W'(4) : TAIL_W'(8);
        end
    end
endmodule

// File: rtl/ilen_esc_class.sv
module ilen_esc_class
    import ilen_pkg::*;
(
    input  logic [7:0]  byte_in,
    output ilen_class_t cls
);
    always_comb begin
        cls.kind = LK_MODRM;
        cls.tail = '0;
        if (byte_in == 8'h38 || byte_in == 8'h3A) begin
            cls.kind = LK_ESC;
        end else if (byte_in[7:3] == 5'b00110) begin
            cls.kind = LK_DONE;
        end else if (byte_in[7:4] == 4'h8) begin
            cls.kind = LK_IMM;
            cls.tail = TAIL_W'(4);
        end
    end
endmodule

// File: rtl/ilen_addr_bytes.sv
module ilen_addr_bytes
    import ilen_pkg::*;
(
    input  logic [1:0]        mod_now,
    input  logic [2:0]        low_now,
    input  logic [1:0]        mod_held,
    output logic              need_sib,
    output logic [TAIL_W-1:0] disp_rm,
    output logic [TAIL_W-1:0] disp_sib
);
    always_comb begin
        need_sib = (mod_now != 2'b11) && (low_now == 3'b100);
        disp_rm  = disp_bytes(mod_now, low_now);
        disp_sib = disp_bytes(mod_held, low_now);
    end
endmodule

// File: rtl/insn_len_scan.sv
module insn_len_scan
    import ilen_pkg::*;
#(
    parameter int MAX_LEN = 15,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    output logic             insn_start,
    output logic             done,
    output logic [LEN_W-1:0] len,
    output logic [1:0]       map_id,
    output logic [1:0]       fault
);
    ilen_state_e       state_q, state_d;
    logic [LEN_W-1:0]  cnt_q, cnt_d, cur_len;
    logic              opsz_q, opsz_d, adsz_q, adsz_d, rexw_q, rexw_d;
    ilen_map_e         map_q, map_d;
    logic [TAIL_W-1:0] imm_q, imm_d, rem_q, rem_d, tsum;
    logic [1:0]        mod_q, mod_d;
    logic              fin, acc;
    ilen_fault_e       fin_flt;

    logic              done_q;
    logic [LEN_W-1:0]  len_q;
    ilen_map_e         dmap_q;
    ilen_fault_e       flt_q;

    ilen_class_t       lead_cls, esc_cls;
    logic              need_sib;
    logic [TAIL_W-1:0] disp_rm, disp_sib;

    ilen_lead_class u_lead (
        .byte_in (in_byte),
        .opsz16  (opsz_q && !rexw_q),
        .adsz32  (adsz_q),
        .cls     (lead_cls)
    );

    ilen_esc_class u_esc (
        .byte_in (in_byte),
        .cls     (esc_cls)
    );

    ilen_addr_bytes u_addr (
        .mod_now  (in_byte[7:6]),
        .low_now  (in_byte[2:0]),
        .mod_held (mod_q),
        .need_sib (need_sib),
        .disp_rm  (disp_rm),
        .disp_sib (disp_sib)
    );

    assign in_ready   = !rst;
    assign acc        = in_valid && in_ready;
    assign insn_start = in_valid && (state_q == ST_PFX) && (cnt_q == '0);
    assign cur_len    = cnt_q + 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cur_len;
        opsz_d  = opsz_q;
        adsz_d  = adsz_q;
        rexw_d  = rexw_q;
        map_d   = map_q;
        imm_d   = imm_q;
        rem_d   = rem_q;
        mod_d   = mod_q;
        fin     = 1'b0;
        fin_flt = FLT_NONE;
        tsum    = '0;
        case (state_q)
            ST_PFX: begin
                case (lead_cls.kind)
                    LK_LEGACY: begin
                        if (in_byte == 8'h66) opsz_d = 1'b1;
                        if (in_byte == 8'h67) adsz_d = 1'b1;
                        rexw_d = 1'b0;
                    end
                    LK_REX:   rexw_d = in_byte[3];
                    LK_ESC: begin
                        state_d = ST_ESC;
                        map_d   = MAP_0F;
                    end
                    LK_MODRM: begin
                        state_d = ST_MODRM;
                        imm_d   = '0;
                    end
                    LK_IMM: begin
                        state_d = ST_TAIL;
                        rem_d   = lead_cls.tail;
                    end
                    LK_INV64: begin
                        fin     = 1'b1;
                        fin_flt = FLT_INV64;
                    end
                    default: begin
                        fin     = 1'b1;
                        fin_flt = FLT_UNSUP;
                    end
                endcase
            end
            ST_ESC: begin
                case (esc_cls.kind)
                    LK_ESC: begin
                        state_d = ST_ESC2;
                        map_d   = in_byte[1] ? MAP_0F3A : MAP_0F38;
                        imm_d   = in_byte[1] ? TAIL_W'(1) : TAIL_W'(0);
                    end
                    LK_DONE: fin = 1'b1;
                    LK_IMM: begin
                        state_d = ST_TAIL;
                        rem_d   = esc_cls.tail;
                    end
                    default: begin
                        state_d = ST_MODRM;
                        imm_d   = '0;
                    end
                endcase
            end
            ST_ESC2: state_d = ST_MODRM;
            ST_MODRM: begin
                mod_d = in_byte[7:6];
                if (need_sib) begin
                    state_d = ST_SIB;
                end else begin
                    tsum = disp_rm + imm_q;
                    if (tsum == '0) fin = 1'b1;
                    else begin
                        state_d = ST_TAIL;
                        rem_d   = tsum;
                    end
                end
            end
            ST_SIB: begin
                tsum = disp_sib + imm_q;
                if (tsum == '0) fin = 1'b1;
                else begin
                    state_d = ST_TAIL;
                    rem_d   = tsum;
                end
            end
            default: begin
                rem_d = rem_q - 1'b1;
                if (rem_q == TAIL_W'(1)) fin = 1'b1;
            end
        endcase
        if (!fin && cur_len == LEN_W'(MAX_LEN)) begin
            fin     = 1'b1;
            fin_flt = FLT_LONG;
        end
        if (fin) begin
            state_d = ST_PFX;
            cnt_d   = '0;
            opsz_d  = 1'b0;
            adsz_d  = 1'b0;
            rexw_d  = 1'b0;
            imm_d   = '0;
            rem_d   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PFX;
            cnt_q   <= '0;
            opsz_q  <= 1'b0;
            adsz_q  <= 1'b0;
            rexw_q  <= 1'b0;
            map_q   <= MAP_PRI;
            imm_q   <= '0;
            rem_q   <= '0;
            mod_q   <= '0;
            done_q  <= 1'b0;
            len_q   <= '0;
            dmap_q  <= MAP_PRI;
            flt_q   <= FLT_NONE;
        end else begin
            done_q <= acc && fin;
            if (acc) begin
                state_q <= state_d;
                cnt_q   <= cnt_d;
                opsz_q  <= opsz_d;
                adsz_q  <= adsz_d;
                rexw_q  <= rexw_d;
                imm_q   <= imm_d;
                rem_q   <= rem_d;
                mod_q   <= mod_d;
                map_q   <= fin ? MAP_PRI : map_d;
                if (fin) begin
                    len_q  <= cur_len;
                    dmap_q <= map_q;
                    flt_q  <= fin_flt;
                end
            end
        end
    end

    assign done   = done_q;
    assign len    = len_q;
    assign map_id = dmap_q;
    assign fault  = flt_q;

    // R1: mid-instruction states always have bytes behind them
    assert_mid_count_R1: assert property (@(posedge clk) disable iff (rst)
        state_q != ST_PFX |-> cnt_q != '0);

    // R2: a length-limit report carries the full limit
    assert_long_len_R2: assert property (@(posedge clk) disable iff (rst)
        (done_q && flt_q == FLT_LONG) |-> len_q == LEN_W'(MAX_LEN));

    // R6: invalid-in-64-bit opcodes come only from the primary map
    assert_inv64_map_R6: assert property (@(posedge clk) disable iff (rst)
        (done_q && flt_q == FLT_INV64) |-> dmap_q == MAP_PRI);

    // R8: pending trailing bytes stay within displacement+immediate reach
    assert_tail_range_R8: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_TAIL |-> (rem_q != '0 && rem_q <= TAIL_W'(8)));

    // R12: a clean three-byte-map instruction spans at least four bytes
    assert_esc_len_R12: assert property (@(posedge clk) disable iff (rst)
        (done_q && flt_q == FLT_NONE && dmap_q[1]) |-> len_q >= LEN_W'(4));

    // R13: an idle beat never produces a report
    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done_q);

endmodule

// File: tb/insn_len_scan_test.sv
module insn_len_scan_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready, insn_start, done;
    logic [3:0] len;
    logic [1:0] map_id, fault;

    int checks = 0;
    int fails  = 0;

    insn_len_scan uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .insn_start(insn_start), .done(done),
        .len(len), .map_id(map_id), .fault(fault)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives n bytes (v right-aligned, first byte most significant) and checks the report
    task automatic run_insn(input string tag, input int n, input logic [127:0] v,
                            input int exp_len, input int exp_map, input int exp_flt,
                            input bit gap = 1'b0);
        bit early = 1'b0;
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_byte  = v[8*(n-1-i) +: 8];
            if (i == 0) begin
                #1;
                chk({tag, " start flag"}, int'(insn_start), 1);
            end
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            if (i < n-1 && done) early = 1'b1;
            if (gap && i == 0) begin
                @(negedge clk);
                if (done) early = 1'b1;
            end
        end
        chk({tag, " early done"}, int'(early), 0);
        chk({tag, " done"},  int'(done),   1);
        chk({tag, " len"},   int'(len),    exp_len);
        chk({tag, " map"},   int'(map_id), exp_map);
        chk({tag, " fault"}, int'(fault),  exp_flt);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset done", int'(done), 0);
        chk("R13 ready in reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 ready after reset", int'(in_ready), 1);
        chk("R1 idle done", int'(done), 0);
    endtask

    task automatic t_arith;
        run_insn("R5 R8 00 mod11", 2, 128'h00C0, 2, 0, 0);
        run_insn("R5 imm8", 2, 128'h047F, 2, 0, 0);
        run_insn("R5 66 imm16", 4, 128'h66053412, 4, 0, 0);
        run_insn("R4 R5 rexw imm32", 6, 128'h480578563412, 6, 0, 0);
        run_insn("R5 66+rexw imm32", 7, 128'h66480578563412, 7, 0, 0);
        run_insn("R4 rex dropped", 5, 128'h4866053412, 5, 0, 0);
    endtask

    task automatic t_addr;
        run_insn("R8 R9 sib disp8", 5, 128'h4801442408, 5, 0, 0);
        run_insn("R8 mod00 rm101", 6, 128'h030511223344, 6, 0, 0);
        run_insn("R8 mod10 disp32", 6, 128'h018011223344, 6, 0, 0);
        run_insn("R9 sib base101", 7, 128'h03042511223344, 7, 0, 0);
        run_insn("R9 sib no disp", 3, 128'h0B0424, 3, 0, 0);
    endtask

    task automatic t_moffs;
        run_insn("R10 moffs64", 9, 128'hA1_1122334455667788, 9, 0, 0);
        run_insn("R10 67 moffs32", 6, 128'h67A211223344, 6, 0, 0);
    endtask

    task automatic t_maps;
        run_insn("R11 0F 32", 2, 128'h0F32, 2, 1, 0);
        run_insn("R11 0F 84 rel32", 6, 128'h0F8411223344, 6, 1, 0);
        run_insn("R11 0F AF modrm", 3, 128'h0FAFC0, 3, 1, 0);
        run_insn("R12 0F38", 4, 128'h0F3800C1, 4, 2, 0);
        run_insn("R12 0F3A imm8", 5, 128'h0F3A0FC108, 5, 3, 0);
        run_insn("R12 0F3A sib disp8 imm8", 7, 128'h0F3A0F44240801, 7, 3, 0);
    endtask

    task automatic t_faults;
        run_insn("R6 06", 1, 128'h06, 1, 0, 2);
        run_insn("R6 66 07", 2, 128'h6607, 2, 0, 2);
        run_insn("R7 90", 1, 128'h90, 1, 0, 1);
        run_insn("R7 27", 1, 128'h27, 1, 0, 1);
    endtask

    task automatic t_limits;
        run_insn("R3 lock+seg", 4, 128'hF02E0008, 4, 0, 0);
        run_insn("R2 R3 fifteen ok", 15, {{13{8'h2E}}, 8'h00, 8'hC0}, 15, 0, 0);
        run_insn("R2 sixteenth", 15, {15{8'h2E}}, 15, 0, 3);
        run_insn("R2 restart", 2, 128'h00C0, 2, 0, 0);
        run_insn("R2 long in tail", 15, {{8{8'h64}}, 8'hA1, {6{8'h11}}}, 15, 0, 3);
    endtask

    task automatic t_handshake;
        run_insn("R13 gap", 2, 128'h0411, 2, 0, 0, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 R13 pulse ends", int'(done), 0);
        @(negedge clk);
        chk("R13 idle quiet", int'(done), 0);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_addr();
        t_moffs();
        t_maps();
        t_faults();
        t_limits();
        t_handshake();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule